// File: doc/BRIEF.md
# Microcoded 8-bit Accumulator Processor

This block is a compact processor whose datapath hangs off a single 8-bit internal bus. A 4-bit program counter fetches from a 16-byte memory that holds both code and data. A microcode sequencer steps through eight clock periods per instruction and emits a 16-bit control word. Each bit of that word enables one source onto the bus, one register load, or one datapath action. Registers A and B feed an adder/subtractor that can update carry and zero flags, and an output register holds the value presented at the block's edge.

Because code and data share one memory, a program may store a computed byte and later execute it as an instruction. A preload port fills the memory while the core is held in reset. The `halted` output rises once a halt instruction reaches its execute step. From then on all state is frozen until the next reset.

Top module: `acc_cpu8`

## Requirements
- R1: While `rst_n` is low, the program counter, step counter, A, B, both flags and `out_value` are cleared and `halted` is 0. Memory contents survive a reset.
- R2: An instruction byte carries the opcode in bits 7:4 and the operand in bits 3:0. The opcodes are 0 no-op, 1 load A from memory, 2 add, 3 subtract, 4 store A, 5 load A with the operand, 6 jump, 7 jump if carry, 8 jump if zero, 14 output and 15 halt. Opcodes 9 to 13 behave as no-ops.
- R3: Every instruction occupies exactly eight clock cycles (steps 0 to 7). Steps without any micro-operation drive an all-zero control word.
- R4: In step 0 the control word enables only PC-onto-bus and memory-address load. In step 1 it enables only memory-onto-bus, instruction load and PC increment. In every step at most one bus source is enabled.
- R5: Load-from-memory sets A to mem[operand], store sets mem[operand] to A, and load-immediate sets A to the operand zero-extended, because only the instruction's low four bits reach the bus.
- R6: Add sets A to A+mem[operand]. Subtract sets A to A+~mem[operand]+1. Carry becomes the 9th bit of that sum and zero becomes 1 when the 8-bit result is 0.
- R7: The flags change only during the ALU write step of add or subtract. Every other instruction, load-immediate included, leaves them unchanged.
- R8: Jump always loads the PC with the operand. Jump-if-carry and jump-if-zero do so only when their flag is 1, and otherwise continue at the next address.
- R9: The output instruction copies A into `out_value` at the end of its step 2. At no other time does `out_value` change, apart from reset.
- R10: A halt instruction raises `halted` from its step 2 onward. While halted, neither the step counter, the PC nor `out_value` changes.
- R11: When `load_en` is 1, `load_data` is written to memory address `load_addr` on the rising clock edge.
- R12: A program that builds an instruction in memory and then executes it produces that instruction's effect. The sequence load-immediate 15, store 15, add 15, store 4, executing location 4, output, jump 14, with a halt at 14 and 0xFF at 14, ends with `out_value` = 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the core registers |
| load_en | input | 1 | Memory preload write enable |
| load_addr | input | 4 | Memory preload address |
| load_data | input | 8 | Memory preload data |
| halted | output | 1 | High while the core is stopped on a halt instruction |
| out_value | output | 8 | Contents of the output register |

## Verification
The conditions hardest to reach from the ports are a flag that was set several instructions earlier steering a later conditional jump, and fetching a byte that the program itself wrote. Neither the flags nor memory are visible at the edge. The stimulus therefore preloads short programs in which a wrong branch decision or a stale fetch ends on a different output value. In one program a flag-neutral load-immediate sits between the arithmetic and the branch. In another, the instruction executed at location 4 is the result of a store. A behavioural instruction-level model of the memory, PC and flags predicts `out_value` and `halted` on every clock.

// File: rtl/acc_cpu8_pkg.sv
package acc_cpu8_pkg;

    parameter int unsigned DATA_W = 8;
    parameter int unsigned ADDR_W = 4;
    parameter int unsigned STEP_W = 3;
    parameter int unsigned CW_W   = 16;

    typedef logic [CW_W-1:0] cword_t;

    // Control word bit positions, most significant first
    localparam int CW_HALT     = 15;
    localparam int CW_MAR_IN   = 14;
    localparam int CW_RAM_IN   = 13;
    localparam int CW_RAM_OUT  = 12;
    localparam int CW_IR_OUT   = 11;
    localparam int CW_IR_IN    = 10;
    localparam int CW_A_IN     = 9;
    localparam int CW_A_OUT    = 8;
    localparam int CW_ALU_OUT  = 7;
    localparam int CW_SUB      = 6;
    localparam int CW_B_IN     = 5;
    localparam int CW_OUT_IN   = 4;
    localparam int CW_PC_EN    = 3;
    localparam int CW_PC_OUT   = 2;
    localparam int CW_JUMP     = 1;
    localparam int CW_FLAG_IN  = 0;

    localparam cword_t M_HALT    = cword_t'(1) << CW_HALT;
    localparam cword_t M_MAR_IN  = cword_t'(1) << CW_MAR_IN;
    localparam cword_t M_RAM_IN  = cword_t'(1) << CW_RAM_IN;
    localparam cword_t M_RAM_OUT = cword_t'(1) << CW_RAM_OUT;
    localparam cword_t M_IR_OUT  = cword_t'(1) << CW_IR_OUT;
    localparam cword_t M_IR_IN   = cword_t'(1) << CW_IR_IN;
    localparam cword_t M_A_IN    = cword_t'(1) << CW_A_IN;
    localparam cword_t M_A_OUT   = cword_t'(1) << CW_A_OUT;
    localparam cword_t M_ALU_OUT = cword_t'(1) << CW_ALU_OUT;
    localparam cword_t M_SUB     = cword_t'(1) << CW_SUB;
    localparam cword_t M_B_IN    = cword_t'(1) << CW_B_IN;
    localparam cword_t M_OUT_IN  = cword_t'(1) << CW_OUT_IN;
    localparam cword_t M_PC_EN   = cword_t'(1) << CW_PC_EN;
    localparam cword_t M_PC_OUT  = cword_t'(1) << CW_PC_OUT;
    localparam cword_t M_JUMP    = cword_t'(1) << CW_JUMP;
    localparam cword_t M_FLAG_IN = cword_t'(1) << CW_FLAG_IN;

    typedef enum logic [3:0] {
        OP_NOP = 4'h0,
        OP_LDA = 4'h1,
        OP_ADD = 4'h2,
        OP_SUB = 4'h3,
        OP_STA = 4'h4,
        OP_LDI = 4'h5,
        OP_JMP = 4'h6,
        OP_JC  = 4'h7,
        OP_JZ  = 4'h8,
        OP_OUT = 4'hE,
        OP_HLT = 4'hF
    } opcode_e;

endpackage

// File: rtl/acc_cpu8_alu.sv
module acc_cpu8_alu #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              zero_o
);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        sum     = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
        res_o   = sum[DATA_W-1:0];
        carry_o = sum[DATA_W];
        zero_o  = (sum[DATA_W-1:0] == '0);
    end

endmodule

// File: rtl/acc_cpu8_ram.sv
module acc_cpu8_ram #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/acc_cpu8_useq.sv
module acc_cpu8_useq
    import acc_cpu8_pkg::*;
#(
    parameter int unsigned OPC_W = 4,
    parameter int unsigned SEQ_W = STEP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             carry_i,
    input  logic             zero_i,
    output logic [SEQ_W-1:0] step_o,
    output cword_t           cword_o
);

    logic [SEQ_W-1:0] step_d, step_q;

    function automatic cword_t exec_word(input logic [OPC_W-1:0] op,
                                         input logic [SEQ_W-1:0] st,
                                         input logic c, input logic z);
        cword_t w;
        w = '0;
        case (st)
            SEQ_W'(2): begin
                case (opcode_e'(op))
                    OP_LDA, OP_ADD, OP_SUB, OP_STA: w = M_IR_OUT | M_MAR_IN;
                    OP_LDI: w = M_IR_OUT | M_A_IN;
                    OP_JMP: w = M_IR_OUT | M_JUMP;
                    OP_JC:  w = c ? (M_IR_OUT | M_JUMP) : '0;
                    OP_JZ:  w = z ? (M_IR_OUT | M_JUMP) : '0;
                    OP_OUT: w = M_A_OUT | M_OUT_IN;
                    OP_HLT: w = M_HALT;
                    default: w = '0;
                endcase
            end
            SEQ_W'(3): begin
                case (opcode_e'(op))
                    OP_LDA:         w = M_RAM_OUT | M_A_IN;
                    OP_ADD, OP_SUB: w = M_RAM_OUT | M_B_IN;
                    OP_STA:         w = M_A_OUT | M_RAM_IN;
                    default:        w = '0;
                endcase
            end
            SEQ_W'(4): begin
                case (opcode_e'(op))
                    OP_ADD:  w = M_ALU_OUT | M_A_IN | M_FLAG_IN;
                    OP_SUB:  w = M_ALU_OUT | M_A_IN | M_SUB | M_FLAG_IN;
                    default: w = '0;
                endcase
            end
            default: w = '0;
        endcase
        return w;
    endfunction

    always_comb begin
        case (step_q)
            SEQ_W'(0): cword_o = M_PC_OUT | M_MAR_IN;
            SEQ_W'(1): cword_o = M_RAM_OUT | M_IR_IN | M_PC_EN;
            default:   cword_o = exec_word(opcode_i, step_q, carry_i, zero_i);
        endcase
        step_d = cword_o[CW_HALT] ? step_q : step_q + SEQ_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else begin
            step_q <= step_d;
        end
    end

    assign step_o = step_q;

endmodule

// File: rtl/acc_cpu8.sv
module acc_cpu8
    import acc_cpu8_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    output logic          halted,
    output logic [DW-1:0] out_value
);

    localparam int unsigned OPC_W = DW - AW;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] mar;
        logic [DW-1:0] ir;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] outr;
        logic          cf;
        logic          zf;
    } core_t;

    core_t cur_q, nxt_d;

    cword_t            cw;
    logic [STEP_W-1:0] step;
    logic [DW-1:0]     bus;
    logic [DW-1:0]     ram_rd;
    logic [DW-1:0]     alu_res;
    logic              alu_c, alu_z;
    logic              ram_we;
    logic [AW-1:0]     ram_wa;
    logic [DW-1:0]     ram_wd;

    acc_cpu8_useq #(.OPC_W(OPC_W), .SEQ_W(STEP_W)) u_useq (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (cur_q.ir[DW-1:AW]),
        .carry_i  (cur_q.cf),
        .zero_i   (cur_q.zf),
        .step_o   (step),
        .cword_o  (cw)
    );

    acc_cpu8_alu #(.DATA_W(DW)) u_alu (
        .a_i     (cur_q.a),
        .b_i     (cur_q.b),
        .sub_i   (cw[CW_SUB]),
        .res_o   (alu_res),
        .carry_o (alu_c),
        .zero_o  (alu_z)
    );

    always_comb begin
        ram_we = load_en | cw[CW_RAM_IN];
        ram_wa = load_en ? load_addr : cur_q.mar;
        ram_wd = load_en ? load_data : bus;
    end

    acc_cpu8_ram #(.DATA_W(DW), .ADDR_W(AW)) u_ram (
        .clk       (clk),
        .wr_en_i   (ram_we),
        .wr_addr_i (ram_wa),
        .wr_data_i (ram_wd),
        .rd_addr_i (cur_q.mar),
        .rd_data_o (ram_rd)
    );

    // Bus: AND-OR multiplexer, sources selected by control bits
    always_comb begin
        bus = '0;
        bus |= {DW{cw[CW_PC_OUT]}}  & {{OPC_W{1'b0}}, cur_q.pc};
        bus |= {DW{cw[CW_RAM_OUT]}} & ram_rd;
        bus |= {DW{cw[CW_IR_OUT]}}  & {{OPC_W{1'b0}}, cur_q.ir[AW-1:0]};
        bus |= {DW{cw[CW_A_OUT]}}   & cur_q.a;
        bus |= {DW{cw[CW_ALU_OUT]}} & alu_res;
    end

    always_comb begin
        nxt_d = cur_q;
        if (cw[CW_MAR_IN]) nxt_d.mar  = bus[AW-1:0];
        if (cw[CW_IR_IN])  nxt_d.ir   = bus;
        if (cw[CW_A_IN])   nxt_d.a    = bus;
        if (cw[CW_B_IN])   nxt_d.b    = bus;
        if (cw[CW_OUT_IN]) nxt_d.outr = bus;
        if (cw[CW_FLAG_IN]) begin
            nxt_d.cf = alu_c;
            nxt_d.zf = alu_z;
        end
        if (cw[CW_JUMP]) begin
            nxt_d.pc = bus[AW-1:0];
        end else if (cw[CW_PC_EN]) begin
            nxt_d.pc = cur_q.pc + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign halted    = cw[CW_HALT];
    assign out_value = cur_q.outr;

endmodule

// File: rtl/acc_cpu8_chk.sv
module acc_cpu8_chk
    import acc_cpu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic [DATA_W-1:0] out_value,
    input logic [STEP_W-1:0] step,
    input cword_t            cw,
    input logic [ADDR_W-1:0] pc,
    input logic              cf,
    input logic              zf
);

    // R3: step counter advances by one (wrapping) every unhalted cycle
    p_step_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> (step == STEP_W'($past(step) + STEP_W'(1))));

    // R4: step 0 is a pure address fetch
    p_fetch_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0) |-> (cw == (M_PC_OUT | M_MAR_IN)));

    // R4: never more than one bus source
    p_one_bus_driver_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cw[CW_PC_OUT], cw[CW_RAM_OUT], cw[CW_IR_OUT],
                  cw[CW_A_OUT], cw[CW_ALU_OUT]}));

    // R7: flags hold without a flag-load step
    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cw[CW_FLAG_IN] |=> $stable({cf, zf}));

    // R9: output register holds without an output-load step
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cw[CW_OUT_IN] |=> $stable(out_value));

    // R10: halt is sticky and freezes state
    p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(step) && $stable(out_value)));

endmodule

bind acc_cpu8 acc_cpu8_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halted    (halted),
    .out_value (out_value),
    .step      (step),
    .cw        (cw),
    .pc        (cur_q.pc),
    .cf        (cur_q.cf),
    .zf        (cur_q.zf)
);

// File: tb/acc_cpu8_bench.sv
module acc_cpu8_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic       halted;
    logic [7:0] out_value;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_total = 0;
    bit cmp_en = 1'b0;

    always #10 clk = ~clk;

    acc_cpu8 u_acc_cpu8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .halted    (halted),
        .out_value (out_value)
    );

    // ---------------- behavioural reference model ----------------
    int   m_mem [16];
    int   m_pc = 0, m_s = 0, m_a = 0, m_ir = 0, m_out = 0;
    bit   m_cf = 0, m_zf = 0, m_halt = 0;

    always @(posedge clk) begin
        int op, opr, t;
        if (load_en) m_mem[load_addr] = load_data;
        if (!rst_n) begin
            m_pc = 0; m_s = 0; m_a = 0; m_out = 0;
            m_cf = 0; m_zf = 0; m_halt = 0;
        end else if (!m_halt) begin
            if (m_s == 1) begin
                m_ir = m_mem[m_pc];
                m_pc = (m_pc + 1) % 16;
                if ((m_ir >> 4) == 15) m_halt = 1;
            end else if (m_s == 2) begin
                op  = m_ir >> 4;
                opr = m_ir % 16;
                case (op)
                    1: m_a = m_mem[opr];
                    2, 3: begin
                        t = (op == 2) ? m_a + m_mem[opr] : m_a + (255 - m_mem[opr]) + 1;
                        m_a  = t % 256;
                        m_cf = (t > 255);
                        m_zf = (m_a == 0);
                    end
                    4: m_mem[opr] = m_a;
                    5: m_a = opr;
                    6: m_pc = opr;
                    7: if (m_cf) m_pc = opr;
                    8: if (m_zf) m_pc = opr;
                    14: m_out = m_a;
                    default: ;
                endcase
            end
            if (!m_halt) m_s = (m_s + 1) % 8;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R5 R6 R9 out_value per cycle", int'(out_value), m_out);
            chk("R4 R10 halted per cycle", int'(halted), int'(m_halt));
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc_total++;
            if (cyc_total > 150000) begin
                n_fail++;
                n_chk++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc_total);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    logic [7:0] prog [16];

    task automatic set_prog(input logic [127:0] img);
        for (int i = 0; i < 16; i++) prog[i] = img[127 - 8*i -: 8];
    endtask

    // Holds reset, optionally preloads (R11), releases, runs until halted
    task automatic run(input bit preload, output int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        if (preload) begin
            for (int i = 0; i < 16; i++) begin
                load_en   = 1'b1;
                load_addr = 4'(i);
                load_data = prog[i];
                @(negedge clk);
            end
            load_en = 1'b0;
        end
        @(negedge clk);
        chk("R1 out_value in reset", int'(out_value), 0);
        chk("R1 halted in reset", int'(halted), 0);
        rst_n  = 1'b1;
        cycles = 0;
        while (!halted && cycles < 3000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        int cy;
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset out_value", int'(out_value), 0);
        chk("R1 reset halted", int'(halted), 0);

        // R12: code built at run time and then executed
        set_prog(128'h5F_4F_2F_44_00_E0_6E_00_00_00_00_00_00_00_FF_00);
        run(1'b1, cy);
        chk("R12 self-modifying result", int'(out_value), 8'hFF);
        chk("R10 halted after program", int'(halted), 1);
        chk("R3 cycles until halted (7 instr x 8 + 2)", cy, 58);
        repeat (40) @(negedge clk);
        chk("R10 out frozen while halted", int'(out_value), 8'hFF);
        chk("R10 still halted", int'(halted), 1);

        // R1: memory survives reset, program reruns from modified image
        run(1'b0, cy);
        chk("R1 rerun without preload", int'(out_value), 8'hFF);

        // R8 taken branches, R6 subtract carry and zero
        set_prog(128'h57_3E_85_E0_F0_E0_78_F0_1D_E0_F0_00_00_42_07_00);
        run(1'b1, cy);
        chk("R8 R6 taken JZ then JC", int'(out_value), 8'h42);
        chk("R10 halted", int'(halted), 1);

        // R8 untaken branches, R2 unused opcode as no-op, R5 load immediate
        set_prog(128'h53_2F_77_87_A5_E0_F0_5C_E0_F0_00_00_00_00_00_02);
        run(1'b1, cy);
        chk("R8 R2 R5 untaken branches", int'(out_value), 8'h05);
        chk("R2 cycles with no-op (6 instr x 8 + 2)", cy, 50);

        // R7 flags survive load immediate, R6 add carry
        set_prog(128'h1E_2F_50_88_77_E0_F0_1D_E0_F0_00_00_00_99_F0_20);
        run(1'b1, cy);
        chk("R7 R6 carry kept across LDI", int'(out_value), 8'h99);
        chk("R11 preload image used", int'(halted), 1);

        cmp_en = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule